// File: doc/BRIEF.md
# I2C Packet Error Check Engine

This block sits beside an I2C byte engine and keeps the CRC8 packet error code of a transfer. The byte engine presents every byte that crosses the bus, including the address byte with its read/write bit, through a one-cycle strobe. While checking is enabled, the block folds each byte into a running CRC8 with generator x^8 + x^2 + x + 1. The CRC is processed most significant bit first and restarts from zero at every start condition.

When the block transmits with a check requested, it raises a send indication after the last data byte, and the byte engine then sends the current CRC value as one extra byte. When the block receives, the byte engine marks the final byte as the check byte. The block compares that byte with its running CRC and returns an ACK/NAK decision to the acknowledge logic. A slave receiver answers ACK on a match and NAK on a mismatch. A master receiver always answers NAK. A sticky error flag records mismatches.

Software owns two control bits: the enable bit for checking and a per-transfer request bit. Hardware clears the request bit on these events:
- start condition
- stop condition
- arbitration loss
- peripheral disable
- completed transmission of the check byte

Top module: `i2c_pec_engine`

## Requirements
- R1: After reset, `crc_value` is 0x00, and `req_status`, `chk_valid`, `chk_nak`, `err_flag` and `pec_send` are 0.
- R2: A `byte_strobe` with `periph_en`=1, `calc_en`=1 and `byte_is_chk`=0 replaces `crc_value`, one clock later, with the CRC8 (polynomial 0x07, MSB first, no final inversion) of the old value and `byte_data`. Starting from 0x00, the bytes 0x31..0x39 give 0xF4.
- R3: `crc_value` does not change on a strobe while `calc_en` is 0, or on a strobe with `byte_is_chk`=1.
- R4: `bus_start` sets `crc_value` to 0x00 and clears the request bit one clock later. It wins over a byte strobe in the same cycle.
- R5: `req_wr` loads `req_wdata` into the request bit only while `periph_en` is 1. `pec_send` = request & `calc_en` & `periph_en` & !`dir_rx`.
- R6: A strobe with `byte_is_chk`=1 and `dir_rx`=0 clears the request bit one clock later. This is the transmitted check byte.
- R7: `bus_stop` clears the request bit one clock later.
- R8: A strobe with `byte_is_chk`=1, `dir_rx`=1, `periph_en`, `calc_en` and the request bit all 1 gives a one-cycle `chk_valid` pulse one clock later. With `is_master`=0, `chk_nak` is 1 exactly when `byte_data` differs from `crc_value`.
- R9: Under the same conditions as R8 but with `is_master`=1, `chk_nak` is 1 together with `chk_valid`, whether or not the bytes match.
- R10: `err_flag` is set one clock after a receive check mismatch and stays set until `err_clr` is pulsed. A mismatch in the same cycle as `err_clr` leaves it set.
- R11: `periph_en`=0 clears `crc_value`, the request bit and `err_flag` one clock later.
- R12: `arb_lost` sets `crc_value` to 0x00 and clears the request bit one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| periph_en | input | 1 | Peripheral enable level |
| calc_en | input | 1 | Checking enable level (control bit) |
| req_wr | input | 1 | Software write strobe for the request bit |
| req_wdata | input | 1 | Value written to the request bit |
| err_clr | input | 1 | Software clear of the sticky error flag |
| bus_start | input | 1 | Start condition generated |
| bus_stop | input | 1 | Stop condition generated |
| arb_lost | input | 1 | Arbitration lost |
| dir_rx | input | 1 | 1 while receiving, 0 while transmitting |
| is_master | input | 1 | 1 when the block is the master |
| byte_strobe | input | 1 | One-cycle pulse per byte moved on the bus |
| byte_data | input | 8 | Byte accompanying the strobe |
| byte_is_chk | input | 1 | The strobed byte is the check byte |
| pec_send | output | 1 | Append the CRC byte after the last data byte |
| req_status | output | 1 | Current request bit |
| crc_value | output | 8 | Running CRC; the byte to transmit as check byte |
| chk_valid | output | 1 | Receive check result valid (one cycle) |
| chk_nak | output | 1 | Reply NAK to the check byte |
| err_flag | output | 1 | Sticky mismatch flag |

## Verification
All state outputs (`crc_value`, `req_status`, `err_flag`) and the check result pair (`chk_valid`, `chk_nak`) are registered, so each of them is due exactly one clock after the stimulus that causes it. `pec_send` is combinational from the request bit and the held level inputs. The bench drives every stimulus on a falling edge and compares every output on the next falling edge, one rising edge later, against a model advanced by the same single step. The directed sequences line up the corner cases within single cycles: start against a strobe, mismatch against error clear, and disable against a pending request.

// File: rtl/pec_pkg.sv
// Shared types and the CRC step function of the packet error check engine.
// Assumes byte-wide transfers and a generator without the implicit top term.
package pec_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    // Bus events that invalidate the current transfer.
    typedef struct packed {
        logic start;
        logic stop;
        logic arb;
        logic off;
    } bus_evt_t;

    // One byte of CRC, most significant data bit first.
    function automatic byte_t crc_step(input byte_t crc_in, input byte_t data, input byte_t poly);
        byte_t c;
        logic  fb;
        c = crc_in;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            fb = c[BYTE_W-1] ^ data[i];
            c  = {c[BYTE_W-2:0], 1'b0};
            if (fb) c = c ^ poly;
        end
        return c;
    endfunction

endpackage

// File: rtl/pec_crc_reg.sv
// Running CRC register.
// Does: clears to INIT on clr, folds one byte per upd pulse. clr has priority.
// Assumes: upd is already qualified by the enables in the parent.
module pec_crc_reg
    import pec_pkg::*;
#(
    parameter byte_t POLY = 8'h07,
    parameter byte_t INIT = 8'h00
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  logic  upd,
    input  byte_t data,
    output byte_t crc
);

    byte_t crc_q;

    // Hold, clear or advance the CRC once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= INIT;
        end else if (clr) begin
            crc_q <= INIT;
        end else if (upd) begin
            crc_q <= crc_step(crc_q, data, POLY);
        end
    end

    assign crc = crc_q;

endmodule

// File: rtl/pec_req_ctrl.sv
// Per-transfer request bit.
// Does: software sets or clears it; hardware clears override the write.
// Assumes: writes are accepted only while the peripheral is enabled.
module pec_req_ctrl
    import pec_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     periph_en,
    input  logic     wr,
    input  logic     wdata,
    input  bus_evt_t evt,
    input  logic     tx_chk_done,
    output logic     req
);

    logic hw_clr;
    logic req_q;

    // Any bus event or the transmitted check byte ends the request.
    always_comb begin
        hw_clr = evt.start | evt.stop | evt.arb | evt.off | tx_chk_done;
    end

    // Register the request bit with hardware clears first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else if (hw_clr) begin
            req_q <= 1'b0;
        end else if (wr && periph_en) begin
            req_q <= wdata;
        end
    end

    assign req = req_q;

endmodule

// File: rtl/pec_rx_check.sv
// Receive-side comparison of the check byte.
// Does: on fire, compares the byte with the running CRC and issues a one-cycle
// result. A master receiver always answers NAK. Mismatches set a sticky flag.
// Assumes: fire is qualified by the enables and the request bit in the parent.
module pec_rx_check
    import pec_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  periph_en,
    input  logic  fire,
    input  logic  is_master,
    input  byte_t rx_byte,
    input  byte_t crc,
    input  logic  err_clr,
    output logic  valid,
    output logic  nak,
    output logic  err
);

    logic mismatch;
    logic valid_q;
    logic nak_q;
    logic err_q;

    // Compare the received check byte with the running code.
    always_comb begin
        mismatch = fire && (rx_byte != crc);
    end

    // Produce the one-cycle ACK/NAK decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            nak_q   <= 1'b0;
        end else begin
            valid_q <= fire;
            nak_q   <= fire && (is_master || mismatch);
        end
    end

    // Sticky error flag, where setting wins over clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (mismatch) begin
            err_q <= 1'b1;
        end else if (err_clr || !periph_en) begin
            err_q <= 1'b0;
        end
    end

    assign valid = valid_q;
    assign nak   = nak_q;
    assign err   = err_q;

endmodule

// File: rtl/i2c_pec_engine.sv
// CRC8 packet error check engine for an I2C byte engine.
// Does: accumulates the CRC over the strobed bytes, tells the byte engine when
// to append the check byte, and judges a received check byte.
// Assumes: byte_strobe lasts one cycle per byte. The address byte is strobed
// like data. The check byte is flagged by byte_is_chk.
module i2c_pec_engine
    import pec_pkg::*;
#(
    parameter byte_t POLY = 8'h07,
    parameter byte_t INIT = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              periph_en,
    input  logic              calc_en,
    input  logic              req_wr,
    input  logic              req_wdata,
    input  logic              err_clr,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              arb_lost,
    input  logic              dir_rx,
    input  logic              is_master,
    input  logic              byte_strobe,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              byte_is_chk,
    output logic              pec_send,
    output logic              req_status,
    output logic [BYTE_W-1:0] crc_value,
    output logic              chk_valid,
    output logic              chk_nak,
    output logic              err_flag
);

    bus_evt_t evt;
    logic     active;
    logic     crc_clr;
    logic     crc_upd;
    logic     tx_chk_done;
    logic     rx_fire;
    logic     req;
    byte_t    crc;

    // Collect the bus events and qualify the byte strobe.
    always_comb begin
        evt.start   = bus_start;
        evt.stop    = bus_stop;
        evt.arb     = arb_lost;
        evt.off     = !periph_en;
        active      = periph_en && calc_en;
        crc_clr     = evt.start || evt.arb || evt.off;
        crc_upd     = byte_strobe && active && !byte_is_chk;
        tx_chk_done = byte_strobe && byte_is_chk && !dir_rx;
        rx_fire     = byte_strobe && byte_is_chk && dir_rx && active && req;
    end

    pec_crc_reg #(
        .POLY (POLY),
        .INIT (INIT)
    ) crc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .upd   (crc_upd),
        .data  (byte_data),
        .crc   (crc)
    );

    pec_req_ctrl req_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .periph_en   (periph_en),
        .wr          (req_wr),
        .wdata       (req_wdata),
        .evt         (evt),
        .tx_chk_done (tx_chk_done),
        .req         (req)
    );

    pec_rx_check chk_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .periph_en (periph_en),
        .fire      (rx_fire),
        .is_master (is_master),
        .rx_byte   (byte_data),
        .crc       (crc),
        .err_clr   (err_clr),
        .valid     (chk_valid),
        .nak       (chk_nak),
        .err       (err_flag)
    );

    // Ask the byte engine to append the check byte while transmitting.
    always_comb begin
        pec_send = req && active && !dir_rx;
    end

    assign req_status = req;
    assign crc_value  = crc;

endmodule

// File: rtl/pec_engine_checker.sv
// Temporal checks on the packet error check engine, bound to its top.
module pec_engine_checker
    import pec_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              periph_en,
    input logic              calc_en,
    input logic              bus_start,
    input logic              bus_stop,
    input logic              arb_lost,
    input logic              dir_rx,
    input logic              is_master,
    input logic              byte_strobe,
    input logic              byte_is_chk,
    input logic              req_status,
    input logic [BYTE_W-1:0] crc_value,
    input logic              chk_valid,
    input logic              chk_nak,
    input logic              err_flag
);

    assert_start_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> (crc_value == '0) && !req_status);

    assert_stop_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> !req_status);

    assert_tx_chk_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_strobe && byte_is_chk && !dir_rx) |=> !req_status);

    assert_hold_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_strobe && !calc_en && periph_en && !bus_start && !arb_lost) |=> $stable(crc_value));

    assert_master_nak_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_strobe && byte_is_chk && dir_rx && is_master && periph_en && calc_en && req_status)
        |=> (chk_valid && chk_nak));

    assert_err_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> (chk_valid && chk_nak));

    assert_disable_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !periph_en |=> ((crc_value == '0) && !req_status && !err_flag));

    assert_arb_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |=> ((crc_value == '0) && !req_status));

endmodule

bind i2c_pec_engine pec_engine_checker checker_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .periph_en   (periph_en),
    .calc_en     (calc_en),
    .bus_start   (bus_start),
    .bus_stop    (bus_stop),
    .arb_lost    (arb_lost),
    .dir_rx      (dir_rx),
    .is_master   (is_master),
    .byte_strobe (byte_strobe),
    .byte_is_chk (byte_is_chk),
    .req_status  (req_status),
    .crc_value   (crc_value),
    .chk_valid   (chk_valid),
    .chk_nak     (chk_nak),
    .err_flag    (err_flag)
);

// File: tb/i2c_pec_engine_tb.sv
// Self-checking bench: directed corner cases plus seeded random cycles,
// compared every cycle against a step model built from the requirements.
module i2c_pec_engine_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       periph_en = 1'b0, calc_en = 1'b0, req_wr = 1'b0, req_wdata = 1'b0;
    logic       err_clr = 1'b0, bus_start = 1'b0, bus_stop = 1'b0, arb_lost = 1'b0;
    logic       dir_rx = 1'b0, is_master = 1'b0, byte_strobe = 1'b0, byte_is_chk = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       pec_send, req_status, chk_valid, chk_nak, err_flag;
    logic [7:0] crc_value;

    int total = 0;
    int bad = 0;

    // Model state.
    logic [7:0] m_crc = 8'h00;
    logic       m_req = 1'b0, m_valid = 1'b0, m_nak = 1'b0, m_err = 1'b0;

    i2c_pec_engine dut_i (
        .clk (clk), .rst_n (rst_n), .periph_en (periph_en), .calc_en (calc_en),
        .req_wr (req_wr), .req_wdata (req_wdata), .err_clr (err_clr),
        .bus_start (bus_start), .bus_stop (bus_stop), .arb_lost (arb_lost),
        .dir_rx (dir_rx), .is_master (is_master), .byte_strobe (byte_strobe),
        .byte_data (byte_data), .byte_is_chk (byte_is_chk), .pec_send (pec_send),
        .req_status (req_status), .crc_value (crc_value), .chk_valid (chk_valid),
        .chk_nak (chk_nak), .err_flag (err_flag)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [7:0] ref_crc(input logic [7:0] c_in, input logic [7:0] d);
        logic [7:0] c;
        c = c_in;
        for (int k = 7; k >= 0; k--) begin
            if (c[7] ^ d[k]) c = {c[6:0], 1'b0} ^ 8'h07;
            else             c = {c[6:0], 1'b0};
        end
        return c;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check({tag, " crc"},   crc_value, m_crc);
        check({tag, " req"},   {7'd0, req_status}, {7'd0, m_req});
        check({tag, " valid"}, {7'd0, chk_valid}, {7'd0, m_valid});
        check({tag, " nak"},   {7'd0, chk_nak}, {7'd0, m_nak});
        check({tag, " err"},   {7'd0, err_flag}, {7'd0, m_err});
        check({tag, " send"},  {7'd0, pec_send}, {7'd0, m_req & calc_en & periph_en & ~dir_rx});
    endtask

    // One clock: drive pulses at a falling edge, advance the model, compare at the next falling edge.
    task automatic step(input logic stb, input logic [7:0] d, input logic chk,
                        input logic st, input logic sp, input logic arb,
                        input logic wr, input logic wd, input logic ec, input string tag);
        logic act, fire, mism;
        byte_strobe = stb; byte_data = d; byte_is_chk = chk;
        bus_start = st; bus_stop = sp; arb_lost = arb;
        req_wr = wr; req_wdata = wd; err_clr = ec;
        act  = periph_en & calc_en;
        fire = stb & chk & dir_rx & act & m_req;
        mism = fire & (d != m_crc);
        m_valid = fire;
        m_nak   = fire & (is_master | mism);
        if (mism)                m_err = 1'b1;
        else if (ec | ~periph_en) m_err = 1'b0;
        if (~periph_en | st | sp | arb | (stb & chk & ~dir_rx)) m_req = 1'b0;
        else if (wr)                                            m_req = wd;
        if (~periph_en | st | arb)   m_crc = 8'h00;
        else if (stb & act & ~chk)   m_crc = ref_crc(m_crc, d);
        @(negedge clk);
        byte_strobe = 1'b0; bus_start = 1'b0; bus_stop = 1'b0; arb_lost = 1'b0;
        req_wr = 1'b0; err_clr = 1'b0; byte_is_chk = 1'b0;
        check_all(tag);
    endtask

    task automatic put(input logic [7:0] d, input string tag);
        step(1'b1, d, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, tag);
    endtask

    task automatic put_chk(input logic [7:0] d, input string tag);
        step(1'b1, d, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, tag);
    endtask

    task automatic set_req(input string tag);
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, tag);
    endtask

    task automatic do_start(input string tag);
        step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, tag);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset");

        periph_en = 1'b1; calc_en = 1'b1; dir_rx = 1'b0;
        @(negedge clk);
        do_start("R4 start");
        for (int i = 0; i < 9; i++) put(8'h31 + 8'(i), "R2 vector");
        check("R2 known vector", crc_value, 8'hF4);

        calc_en = 1'b0;
        put(8'hA5, "R3 calc off");
        check("R3 calc off holds", crc_value, 8'hF4);
        calc_en = 1'b1;

        set_req("R5 request write");
        check("R5 send raised", {7'd0, pec_send}, 8'h01);
        put_chk(crc_value, "R6 tx check byte");
        check("R6 request cleared", {7'd0, req_status}, 8'h00);
        check("R3 check byte not folded", crc_value, 8'hF4);

        step(1'b1, 8'h55, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R4 start beats strobe");
        check("R4 start beats strobe value", crc_value, 8'h00);

        periph_en = 1'b0;
        set_req("R5 write while disabled");
        check("R5 write ignored", {7'd0, req_status}, 8'h00);
        periph_en = 1'b1;

        dir_rx = 1'b1; is_master = 1'b0;
        do_start("R8 rx start");
        set_req("R8 rx request");
        put(8'hA1, "R8 address");
        put(8'h3C, "R8 data");
        put_chk(m_crc, "R8 slave match");
        check("R8 match acks", {6'd0, chk_valid, chk_nak}, 8'h02);
        put_chk(~m_crc, "R10 slave mismatch");
        check("R8 mismatch naks", {6'd0, chk_valid, chk_nak}, 8'h03);
        check("R10 error set", {7'd0, err_flag}, 8'h01);
        step(1'b1, ~m_crc, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R10 set beats clear");
        check("R10 set beats clear value", {7'd0, err_flag}, 8'h01);
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R10 clear");
        check("R10 cleared", {7'd0, err_flag}, 8'h00);

        is_master = 1'b1;
        put_chk(m_crc, "R9 master match");
        check("R9 master naks", {6'd0, chk_valid, chk_nak}, 8'h03);
        check("R9 no error on match", {7'd0, err_flag}, 8'h00);
        is_master = 1'b0;

        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R7 stop");
        check("R7 stop clears", {7'd0, req_status}, 8'h00);

        set_req("R12 request");
        put(8'h77, "R12 byte");
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R12 arb lost");
        check("R12 crc dropped", crc_value, 8'h00);
        check("R12 request dropped", {7'd0, req_status}, 8'h00);

        set_req("R11 request");
        put(8'h12, "R11 byte");
        put_chk(8'h00, "R11 mismatch");
        periph_en = 1'b0;
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R11 disable");
        check("R11 all cleared", {crc_value}, 8'h00);
        check("R11 flags cleared", {6'd0, req_status, err_flag}, 8'h00);
        periph_en = 1'b1;

        // Seeded random traffic across both directions and roles.
        for (int n = 0; n < 600; n++) begin
            int unsigned r;
            r = $urandom;
            calc_en   = ($urandom % 8) != 0;
            dir_rx    = r[0];
            is_master = r[1];
            periph_en = ($urandom % 20) != 0;
            step(r[4:2] != 0, 8'($urandom), r[7:5] == 0, r[12:8] == 0, r[17:13] == 0,
                 r[22:18] == 0, r[25:23] == 0, 1'b1, r[30:26] == 0, "R2/R8 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule